// File: doc/BRIEF.md
# Reduced-Resolution Quadrature Encoder Emulator

This block turns a 16-bit angular position word into incremental encoder signals: two phase outputs in quadrature and an index marker. The number of encoder lines is chosen with a 2-bit code that is separate from the resolution of the position word. A tracking loop can therefore run at its finest setting, with its narrower bandwidth, while the encoder outputs run at 10, 12 or 14 bits. No divide-down logic is needed outside the block.

The position word is MSB-aligned: at an effective encoder resolution of E bits, the top E bits of the word form the target count. An internal count follows that target by one quadrature state per clock, always in the shorter direction around the circle, so a large jump is played out as a legal burst of edges. The phase outputs and the index come from that count. An encoder code that asks for more bits than the position resolution provides is limited to the position resolution.

Top module: `qenc_emul`

## Requirements
- R1: A resolution code maps to a bit count E as 2'b00 = 10, 2'b01 = 12, 2'b10 = 14, 2'b11 = 16. The internal count wraps modulo 2^E, so one revolution gives 2^(E-2) cycles of phase A.
- R2: While `rst` is high and on the first cycle after it, the stored encoder code is 2'b11 (16 bits) and the count is zero, so `enc_a` = 0, `enc_b` = 0 and `enc_idx` = 1.
- R3: `enc_res` is stored only on a clock where `enc_res_wr` is 1. Changing `enc_res` while `enc_res_wr` is 0 has no effect on the outputs.
- R4: The effective resolution is the smaller of the stored encoder code and `pos_res`.
- R5: With the count bits c1 and c0, `enc_a` = c1 XOR c0 and `enc_b` = c1. An increasing count therefore gives (A,B) = 00, 10, 11, 01, and A leads B. A decreasing count reverses the order, and B leads A.
- R6: Each clock the count moves by at most one step toward the target. Let d be (target - count) mod 2^E. If d = 0 the count holds. If 0 < d < 2^(E-1) it increments. Otherwise it decrements, so a distance of exactly half a revolution is taken downward.
- R7: `enc_idx` is 1 exactly when the count is zero.
- R8: On a clock where the effective resolution differs from the previous clock, the count loads the target directly. The new value appears on the outputs one clock later.
- R9: The target is `pos` shifted right by 16 - E.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pos | input | 16 | MSB-aligned angular position word |
| pos_res | input | 2 | Resolution code of the position word |
| enc_res | input | 2 | Requested encoder resolution code |
| enc_res_wr | input | 1 | Store strobe for `enc_res` |
| enc_a | output | 1 | Quadrature phase A |
| enc_b | output | 1 | Quadrature phase B |
| enc_idx | output | 1 | Index, high at count zero |

## Verification
The assertions check four things on every cycle:
- the phase pair never changes both bits at once, except after a resolution change;
- the index only occurs with both phases low;
- the effective resolution never exceeds the position resolution, and the stored code holds without a strobe;
- the count stays within the effective width.

Some behaviours only the bench scenarios can show:
- the count moves in the shorter direction, and a half-revolution distance is taken downward;
- a large jump takes exactly as many clocks as its distance;
- the truncation applies at each of 10, 12 and 14 bits;
- the count reloads when the clamp or the code changes.

// File: rtl/qenc_pkg.sv
package qenc_pkg;
    localparam int POS_W = 16;
    localparam int MAX_SHIFT = 6;

    typedef logic [1:0]       res_code_t;
    typedef logic [POS_W-1:0] pos_t;

    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2
    } step_t;

    typedef struct packed {
        logic a;
        logic b;
    } quad_t;

    function automatic int unsigned res_shift(res_code_t c);
        return MAX_SHIFT - 2 * int'(c);
    endfunction

    function automatic pos_t res_mask(res_code_t c);
        return pos_t'({POS_W{1'b1}} >> res_shift(c));
    endfunction

    function automatic res_code_t res_min(res_code_t x, res_code_t y);
        return (x < y) ? x : y;
    endfunction

    function automatic quad_t gray_phase(logic [1:0] c);
        quad_t q;
        q.a = c[1] ^ c[0];
        q.b = c[1];
        return q;
    endfunction
endpackage

// File: rtl/qenc_res_sel.sv
module qenc_res_sel
    import qenc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      enc_res_wr,
    input  res_code_t enc_res,
    input  res_code_t pos_res,
    output res_code_t enc_q,
    output res_code_t eff,
    output logic      resync
);
    res_code_t prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            enc_q  <= 2'b11;
            prev_q <= 2'b11;
        end else begin
            if (enc_res_wr) enc_q <= enc_res;
            prev_q <= eff;
        end
    end

    always_comb begin
        eff    = res_min(enc_q, pos_res);
        resync = (eff != prev_q);
    end
endmodule

// File: rtl/qenc_tracker.sv
module qenc_tracker
    import qenc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  pos_t      pos,
    input  res_code_t eff,
    input  logic      resync,
    output pos_t      cnt
);
    pos_t  target;
    pos_t  mask;
    pos_t  diff;
    step_t step;

    always_comb begin
        mask   = res_mask(eff);
        target = pos >> res_shift(eff);
        diff   = (target - cnt) & mask;
        if (diff == '0)
            step = STEP_HOLD;
        else if ((diff & ~(mask >> 1)) == '0)
            step = STEP_UP;
        else
            step = STEP_DOWN;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (resync) begin
            cnt <= target;
        end else begin
            case (step)
                STEP_UP:   cnt <= (cnt + pos_t'(1)) & mask;
                STEP_DOWN: cnt <= (cnt - pos_t'(1)) & mask;
                default:   cnt <= cnt;
            endcase
        end
    end
endmodule

// File: rtl/qenc_phase_out.sv
module qenc_phase_out
    import qenc_pkg::*;
(
    input  pos_t cnt,
    output logic enc_a,
    output logic enc_b,
    output logic enc_idx
);
    quad_t q;

    always_comb begin
        q       = gray_phase(cnt[1:0]);
        enc_a   = q.a;
        enc_b   = q.b;
        enc_idx = (cnt == '0);
    end
endmodule

// File: rtl/qenc_emul.sv
module qenc_emul
    import qenc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [15:0] pos,
    input  logic [1:0] pos_res,
    input  logic [1:0] enc_res,
    input  logic       enc_res_wr,
    output logic       enc_a,
    output logic       enc_b,
    output logic       enc_idx
);
    res_code_t enc_q;
    res_code_t eff;
    logic      resync;
    pos_t      cnt;

    qenc_res_sel u_res_sel (
        .clk        (clk),
        .rst        (rst),
        .enc_res_wr (enc_res_wr),
        .enc_res    (enc_res),
        .pos_res    (pos_res),
        .enc_q      (enc_q),
        .eff        (eff),
        .resync     (resync)
    );

    qenc_tracker u_tracker (
        .clk    (clk),
        .rst    (rst),
        .pos    (pos),
        .eff    (eff),
        .resync (resync),
        .cnt    (cnt)
    );

    qenc_phase_out u_phase_out (
        .cnt     (cnt),
        .enc_a   (enc_a),
        .enc_b   (enc_b),
        .enc_idx (enc_idx)
    );
endmodule

// File: rtl/qenc_emul_chk.sv
module qenc_emul_chk
    import qenc_pkg::*;
(
    input logic      clk,
    input logic      rst,
    input logic      enc_a,
    input logic      enc_b,
    input logic      enc_idx,
    input logic      enc_res_wr,
    input res_code_t pos_res,
    input res_code_t enc_q,
    input res_code_t eff,
    input logic      resync,
    input pos_t      cnt
);
    // R6: no more than one quadrature state per clock outside a resync
    p_one_step_r6: assert property (@(posedge clk) disable iff (rst)
        !resync |=> ($countones({enc_a, enc_b} ^ $past({enc_a, enc_b})) <= 1));

    // R2: default code and zero count after reset
    p_reset_default_r2: assert property (@(posedge clk)
        rst |=> (enc_q == 2'b11 && cnt == '0));

    // R3: stored code holds without a strobe
    p_code_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !enc_res_wr |=> $stable(enc_q));

    // R4: effective resolution never exceeds either request
    p_clamp_r4: assert property (@(posedge clk) disable iff (rst)
        (eff <= pos_res) && (eff <= enc_q));

    // R1: count stays within the effective width once settled
    p_count_range_r1: assert property (@(posedge clk) disable iff (rst)
        !resync |-> ((cnt & ~res_mask(eff)) == '0));

    // R7: index only at the all-low phase state
    p_index_phase_r7: assert property (@(posedge clk) disable iff (rst)
        enc_idx |-> (!enc_a && !enc_b));
endmodule

bind qenc_emul qenc_emul_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .enc_a      (enc_a),
    .enc_b      (enc_b),
    .enc_idx    (enc_idx),
    .enc_res_wr (enc_res_wr),
    .pos_res    (pos_res),
    .enc_q      (enc_q),
    .eff        (eff),
    .resync     (resync),
    .cnt        (cnt)
);

// File: tb/qenc_emul_bench.sv
module qenc_emul_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] pos = '0;
    logic [1:0]  pos_res = 2'b11;
    logic [1:0]  enc_res = 2'b11;
    logic        enc_res_wr = 1'b0;
    logic        enc_a, enc_b, enc_idx;

    int checks = 0;
    int errors = 0;
    string cur = "R5";
    bit done = 1'b0;

    always #10 clk = ~clk;

    qenc_emul u_qenc_emul (
        .clk(clk), .rst(rst), .pos(pos), .pos_res(pos_res),
        .enc_res(enc_res), .enc_res_wr(enc_res_wr),
        .enc_a(enc_a), .enc_b(enc_b), .enc_idx(enc_idx)
    );

    // reference model, built from the requirements
    logic [1:0]  m_enc, m_prev, m_eff;
    logic [15:0] m_cnt, m_tgt, m_mask, m_d;
    int          m_bits;

    function automatic int bits_of(logic [1:0] c);   // R1
        return 10 + 2 * int'(c);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_enc  <= 2'b11;
            m_prev <= 2'b11;
            m_cnt  <= '0;
        end else begin
            m_eff  = (m_enc < pos_res) ? m_enc : pos_res;      // R4
            m_bits = bits_of(m_eff);
            m_mask = 16'((32'd1 << m_bits) - 1);
            m_tgt  = pos >> (16 - m_bits);                     // R9
            if (enc_res_wr) m_enc <= enc_res;                  // R3
            m_prev <= m_eff;
            if (m_eff != m_prev) begin
                m_cnt <= m_tgt;                                // R8
            end else begin
                m_d = (m_tgt - m_cnt) & m_mask;                // R6
                if (m_d == 0)
                    m_cnt <= m_cnt;
                else if (int'(m_d) < (1 << (m_bits - 1)))
                    m_cnt <= (m_cnt + 16'd1) & m_mask;
                else
                    m_cnt <= (m_cnt - 16'd1) & m_mask;
            end
        end
    end

    task automatic chk(string req, string what, logic [2:0] got, logic [2:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got a,b,idx=%b expected %b", req, what, got, exp);
        end
    endtask

    function automatic logic [2:0] expect_of(logic [15:0] c);  // R5, R7
        return {c[1] ^ c[0], c[1], (c == 16'd0)};
    endfunction

    // continuous comparison against the model
    always @(negedge clk) begin
        if (!rst && !done)
            chk(cur, "model", {enc_a, enc_b, enc_idx}, expect_of(m_cnt));
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_code(logic [1:0] c);
        enc_res = c; enc_res_wr = 1'b1;
        tick(1);
        enc_res_wr = 1'b0;
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        tick(3);
        rst = 1'b0;
        tick(1);
        // R2: reset state
        chk("R2", "reset", {enc_a, enc_b, enc_idx}, 3'b001);

        // R5: forward then reverse at 16 bits
        cur = "R5";
        for (int i = 1; i <= 8; i++) begin pos = 16'(i); tick(1); end
        tick(1);
        chk("R5", "forward to 8", {enc_a, enc_b, enc_idx}, 3'b000);
        pos = 16'd7; tick(1);
        chk("R5", "reverse to 7", {enc_a, enc_b, enc_idx}, 3'b010);
        pos = 16'd0; tick(10);

        // R3: code change without strobe is ignored (still 16 bits)
        cur = "R3";
        enc_res = 2'b00; tick(2);
        pos = 16'd1; tick(1);
        chk("R3", "ignored code", {enc_a, enc_b, enc_idx}, 3'b100);
        pos = 16'd0; tick(2);

        // R1, R9: 10-bit encoder, pos LSB below truncation ignored
        cur = "R1";
        set_code(2'b00); tick(2);
        pos = 16'h003F; tick(2);
        chk("R9", "below truncation", {enc_a, enc_b, enc_idx}, 3'b001);
        pos = 16'h0040; tick(1);
        chk("R1", "10-bit step", {enc_a, enc_b, enc_idx}, 3'b100);
        pos = 16'h0000; tick(2);

        // R6: half distance goes downward
        cur = "R6";
        pos = 16'h8000; tick(1);
        chk("R6", "half down", {enc_a, enc_b, enc_idx}, 3'b010);
        tick(600);
        // R6: large jump then hold
        pos = 16'h0140; tick(10);

        // R4: clamp to position resolution 12 with encoder code 16
        cur = "R4";
        set_code(2'b11);
        pos_res = 2'b01; pos = 16'h0010; tick(3);
        chk("R4", "clamp to 12", {enc_a, enc_b, enc_idx}, 3'b100);

        // R8: code 14 with pos 16 resyncs on change
        cur = "R8";
        pos_res = 2'b11; set_code(2'b10);
        pos = 16'h0008; tick(2);
        chk("R8", "resync 14", {enc_a, enc_b, enc_idx}, 3'b110);

        // R7: index on wrap
        cur = "R7";
        pos = 16'h0000; tick(4);
        chk("R7", "index", {enc_a, enc_b, enc_idx}, 3'b001);

        // random mix
        cur = "R6";
        for (int i = 0; i < 6000; i++) begin
            if ($urandom % 400 == 0) begin
                enc_res = 2'($urandom); enc_res_wr = 1'b1;
            end else begin
                enc_res_wr = 1'b0;
            end
            if ($urandom % 700 == 0) pos_res = 2'($urandom);
            if ($urandom % 900 == 0)
                pos = 16'($urandom);
            else
                pos = pos + 16'(int'($urandom % 161) - 80);
            tick(1);
        end
        enc_res_wr = 1'b0;
        tick(2);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule